// File: doc/BRIEF.md
# Dual-Core Hardware Spinlock Bank

This block holds a bank of hardware mutual-exclusion flags shared by two processor cores. Each flag sits at its own word address inside a contiguous window. A core takes a flag by reading its address: one access both tests the flag and sets it. The read returns a one-hot word naming the flag on success, or zero if the flag was already taken. Writing the same address with any value frees the flag. The write data is not used, so the ports carry no write-data bus.

Each core has its own simple register port with an address, a read strobe, a write strobe and a registered read-data bus. Read data appears on the clock after the strobe. A separate status address returns the whole bank as a bitmap. When both cores contend in one cycle, releases are applied before claims, and core 0 is served before core 1. Software can therefore rely on a fixed, repeatable outcome.

Top module: `hw_lock_bank`

## Requirements
- R1: After synchronous reset every flag is free, and both read-data buses read zero.
- R2: A read of a free flag's address claims it. On the next clock that core's read data is 1 shifted left by the flag number, with flag n at byte address LOCK_BASE + 4*n. From then on the flag shows as taken.
- R3: A read of a flag that is already taken returns zero and leaves the flag taken.
- R4: A write strobe to a flag's address frees that flag, whichever core took it.
- R5: If both cores read the same free flag in one cycle, core 0 receives the one-hot value, core 1 receives zero, and the flag is taken once.
- R6: If one core frees a flag in the same cycle the other core reads it, the free is applied first, so the read claims the flag and returns its one-hot value.
- R7: Reads by the two cores of different free flags in one cycle both succeed.
- R8: A read of STATUS_ADDR returns the bitmap of all flags at the start of that cycle (bit n set means flag n is taken). It changes no flag, and a write to STATUS_ADDR changes no flag.
- R9: A read of an address outside the flag window and not equal to STATUS_ADDR returns zero. A write to such an address frees no flag.
- R10: Read data is registered. In a cycle that follows one with no read strobe on a port, that port's read data is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| c0_addr | input | ADDR_W | Core 0 byte address |
| c0_rd | input | 1 | Core 0 read strobe (claim or status read) |
| c0_wr | input | 1 | Core 0 write strobe (release) |
| c0_rdata | output | DATA_W | Core 0 registered read data |
| c1_addr | input | ADDR_W | Core 1 byte address |
| c1_rd | input | 1 | Core 1 read strobe (claim or status read) |
| c1_wr | input | 1 | Core 1 write strobe (release) |
| c1_rdata | output | DATA_W | Core 1 registered read data |

## Verification
The claim path is tried on flags at both ends of the window (0 and 31) and in the middle, from each core alone. This separates index decoding errors from one-hot encoding errors. Contended patterns cover both cores on one flag, both cores on different flags, and a release by one core against a claim by the other. Together these show whether the priority order and the release-before-claim order are right. Status reads, status writes and accesses just outside the window show whether decoding leaks side effects into the flag state.

// File: rtl/hw_lock_pkg.sv
package hw_lock_pkg;

  // byte lanes per lock word and the shift that turns a byte offset into an index
  localparam int unsigned WORD_BYTES = 4;
  localparam int unsigned WORD_SHIFT = 2;

  // what the registered read mux returns on the next cycle
  typedef enum logic [1:0] {
    RSEL_NONE   = 2'd0,
    RSEL_LOCK   = 2'd1,
    RSEL_STATUS = 2'd2
  } rsel_e;

endpackage

// File: rtl/lock_port_decode.sv
module lock_port_decode
  import hw_lock_pkg::*;
#(
  parameter int unsigned        ADDR_W      = 12,
  parameter int unsigned        NUM_LOCKS   = 32,
  parameter logic [ADDR_W-1:0]  LOCK_BASE   = 12'h200,
  parameter logic [ADDR_W-1:0]  STATUS_ADDR = 12'h1FC
) (
  input  logic [ADDR_W-1:0]    addr,
  input  logic                 rd,
  input  logic                 wr,
  output logic [NUM_LOCKS-1:0] claim_vec,
  output logic [NUM_LOCKS-1:0] release_vec,
  output rsel_e                rsel
);

  localparam int unsigned IDX_W     = (NUM_LOCKS > 1) ? $clog2(NUM_LOCKS) : 1;
  localparam int unsigned WIN_BYTES = NUM_LOCKS * WORD_BYTES;

  logic [ADDR_W-1:0] offset;
  logic [IDX_W-1:0]  idx;
  logic              in_win;
  logic              is_status;

  assign offset    = addr - LOCK_BASE;
  assign in_win    = (addr >= LOCK_BASE) && (offset < ADDR_W'(WIN_BYTES));
  assign idx       = offset[WORD_SHIFT +: IDX_W];
  assign is_status = (addr == STATUS_ADDR);

  for (genvar i = 0; i < NUM_LOCKS; i++) begin : g_sel
    logic sel;
    assign sel            = in_win && (idx == IDX_W'(i));
    assign claim_vec[i]   = rd && sel;
    assign release_vec[i] = wr && sel;
  end

  always_comb begin
    rsel = RSEL_NONE;
    if (rd && in_win)         rsel = RSEL_LOCK;
    else if (rd && is_status) rsel = RSEL_STATUS;
  end

endmodule

// File: rtl/lock_state_array.sv
module lock_state_array #(
  parameter int unsigned NUM_LOCKS = 32,
  parameter int unsigned NUM_PORTS = 2
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic [NUM_PORTS-1:0][NUM_LOCKS-1:0] claim,
  input  logic [NUM_PORTS-1:0][NUM_LOCKS-1:0] release_req,
  output logic [NUM_PORTS-1:0][NUM_LOCKS-1:0] grant,
  output logic [NUM_LOCKS-1:0]                held
);

  logic [NUM_LOCKS-1:0] held_q;
  logic [NUM_LOCKS-1:0] held_next;

  for (genvar i = 0; i < NUM_LOCKS; i++) begin : g_lock
    logic [NUM_PORTS-1:0] rel_col;
    logic [NUM_PORTS:0]   taken;

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_rel
      assign rel_col[p] = release_req[p][i];
    end

    // releases land first, then ports are served in index order
    assign taken[0] = held_q[i] && !(|rel_col);

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_arb
      assign grant[p][i] = claim[p][i] && !taken[p];
      assign taken[p+1]  = taken[p] || grant[p][i];
    end

    assign held_next[i] = taken[NUM_PORTS];
  end

  always_ff @(posedge clk) begin
    if (rst) held_q <= '0;
    else     held_q <= held_next;
  end

  assign held = held_q;

endmodule

// File: rtl/lock_read_port.sv
module lock_read_port
  import hw_lock_pkg::*;
#(
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned NUM_LOCKS = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  rsel_e                rsel,
  input  logic [NUM_LOCKS-1:0] grant,
  input  logic [NUM_LOCKS-1:0] held,
  output logic [DATA_W-1:0]    rdata
);

  logic [DATA_W-1:0] rdata_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else begin
      case (rsel)
        RSEL_LOCK:   rdata_q <= DATA_W'(grant);
        RSEL_STATUS: rdata_q <= DATA_W'(held);
        default:     rdata_q <= '0;
      endcase
    end
  end

  assign rdata = rdata_q;

endmodule

// File: rtl/hw_lock_bank.sv
module hw_lock_bank
  import hw_lock_pkg::*;
#(
  parameter int unsigned       ADDR_W      = 12,
  parameter int unsigned       DATA_W      = 32,
  parameter int unsigned       NUM_LOCKS   = 32,
  parameter logic [ADDR_W-1:0] LOCK_BASE   = 12'h200,
  parameter logic [ADDR_W-1:0] STATUS_ADDR = 12'h1FC
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] c0_addr,
  input  logic              c0_rd,
  input  logic              c0_wr,
  output logic [DATA_W-1:0] c0_rdata,
  input  logic [ADDR_W-1:0] c1_addr,
  input  logic              c1_rd,
  input  logic              c1_wr,
  output logic [DATA_W-1:0] c1_rdata
);

  localparam int unsigned NUM_PORTS = 2;

  logic [NUM_PORTS-1:0][ADDR_W-1:0]    p_addr;
  logic [NUM_PORTS-1:0]                p_rd;
  logic [NUM_PORTS-1:0]                p_wr;
  logic [NUM_PORTS-1:0][DATA_W-1:0]    p_rdata;
  logic [NUM_PORTS-1:0][NUM_LOCKS-1:0] claim;
  logic [NUM_PORTS-1:0][NUM_LOCKS-1:0] release_req;
  logic [NUM_PORTS-1:0][NUM_LOCKS-1:0] grant;
  rsel_e                               rsel [NUM_PORTS];
  logic [NUM_LOCKS-1:0]                held_q;

  assign p_addr   = {c1_addr, c0_addr};
  assign p_rd     = {c1_rd, c0_rd};
  assign p_wr     = {c1_wr, c0_wr};
  assign c0_rdata = p_rdata[0];
  assign c1_rdata = p_rdata[1];

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    lock_port_decode #(
      .ADDR_W      (ADDR_W),
      .NUM_LOCKS   (NUM_LOCKS),
      .LOCK_BASE   (LOCK_BASE),
      .STATUS_ADDR (STATUS_ADDR)
    ) u_dec (
      .addr        (p_addr[p]),
      .rd          (p_rd[p]),
      .wr          (p_wr[p]),
      .claim_vec   (claim[p]),
      .release_vec (release_req[p]),
      .rsel        (rsel[p])
    );

    lock_read_port #(
      .DATA_W    (DATA_W),
      .NUM_LOCKS (NUM_LOCKS)
    ) u_rd (
      .clk   (clk),
      .rst   (rst),
      .rsel  (rsel[p]),
      .grant (grant[p]),
      .held  (held_q),
      .rdata (p_rdata[p])
    );
  end

  lock_state_array #(
    .NUM_LOCKS (NUM_LOCKS),
    .NUM_PORTS (NUM_PORTS)
  ) u_state (
    .clk         (clk),
    .rst         (rst),
    .claim       (claim),
    .release_req (release_req),
    .grant       (grant),
    .held        (held_q)
  );

endmodule

// File: rtl/hw_lock_bank_chk.sv
module hw_lock_bank_chk #(
  parameter int unsigned       ADDR_W      = 12,
  parameter int unsigned       DATA_W      = 32,
  parameter int unsigned       NUM_LOCKS   = 32,
  parameter logic [ADDR_W-1:0] LOCK_BASE   = 12'h200,
  parameter logic [ADDR_W-1:0] STATUS_ADDR = 12'h1FC
) (
  input logic                 clk,
  input logic                 rst,
  input logic [ADDR_W-1:0]    c0_addr,
  input logic                 c0_rd,
  input logic [DATA_W-1:0]    c0_rdata,
  input logic [ADDR_W-1:0]    c1_addr,
  input logic                 c1_rd,
  input logic [DATA_W-1:0]    c1_rdata,
  input logic [NUM_LOCKS-1:0] held
);

  localparam int unsigned WIN_BYTES = NUM_LOCKS * 4;

  logic [ADDR_W-1:0] c0_off, c1_off;
  logic              c0_lock_rd, c1_lock_rd;

  assign c0_off     = c0_addr - LOCK_BASE;
  assign c1_off     = c1_addr - LOCK_BASE;
  assign c0_lock_rd = c0_rd && (c0_addr >= LOCK_BASE) && (c0_off < ADDR_W'(WIN_BYTES));
  assign c1_lock_rd = c1_rd && (c1_addr >= LOCK_BASE) && (c1_off < ADDR_W'(WIN_BYTES));

  assert_idle_zero_R10: assert property (@(posedge clk) disable iff (rst)
    !c0_rd |=> (c0_rdata == '0));

  assert_claim_onehot_R2: assert property (@(posedge clk) disable iff (rst)
    c0_lock_rd |=> $onehot0(c0_rdata));

  assert_claim_marks_held_R2: assert property (@(posedge clk) disable iff (rst)
    c0_lock_rd |=> ((c0_rdata & ~DATA_W'(held)) == '0));

  assert_core0_priority_R5: assert property (@(posedge clk) disable iff (rst)
    (c0_lock_rd && c1_lock_rd && (c0_addr[ADDR_W-1:2] == c1_addr[ADDR_W-1:2]))
      |=> (c1_rdata == '0));

  assert_single_owner_R5: assert property (@(posedge clk) disable iff (rst)
    (c0_lock_rd && c1_lock_rd) |=> ((c0_rdata & c1_rdata) == '0));

endmodule

bind hw_lock_bank hw_lock_bank_chk #(
  .ADDR_W      (ADDR_W),
  .DATA_W      (DATA_W),
  .NUM_LOCKS   (NUM_LOCKS),
  .LOCK_BASE   (LOCK_BASE),
  .STATUS_ADDR (STATUS_ADDR)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .c0_addr  (c0_addr),
  .c0_rd    (c0_rd),
  .c0_rdata (c0_rdata),
  .c1_addr  (c1_addr),
  .c1_rd    (c1_rd),
  .c1_rdata (c1_rdata),
  .held     (held_q)
);

// File: tb/test_hw_lock_bank.sv
module test_hw_lock_bank;

  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned ADDR_W     = 12;
  localparam int unsigned DATA_W     = 32;
  localparam logic [ADDR_W-1:0] LOCK_BASE   = 12'h200;
  localparam logic [ADDR_W-1:0] STATUS_ADDR = 12'h1FC;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [ADDR_W-1:0] c0_addr = '0, c1_addr = '0;
  logic              c0_rd = 1'b0, c0_wr = 1'b0, c1_rd = 1'b0, c1_wr = 1'b0;
  logic [DATA_W-1:0] c0_rdata, c1_rdata;
  logic [DATA_W-1:0] got0, got1;

  int vectors = 0;
  int errors  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hw_lock_bank #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_LOCKS(32),
    .LOCK_BASE(LOCK_BASE), .STATUS_ADDR(STATUS_ADDR)
  ) i_hw_lock_bank (
    .clk(clk), .rst(rst),
    .c0_addr(c0_addr), .c0_rd(c0_rd), .c0_wr(c0_wr), .c0_rdata(c0_rdata),
    .c1_addr(c1_addr), .c1_rd(c1_rd), .c1_wr(c1_wr), .c1_rdata(c1_rdata)
  );

  function automatic logic [ADDR_W-1:0] la(input int n);
    return LOCK_BASE + ADDR_W'(n * 4);
  endfunction

  task automatic check(input string req, input logic [DATA_W-1:0] act,
                       input logic [DATA_W-1:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // drive one cycle on both ports; results are sampled at the following negedge
  task automatic step(input logic r0, input logic w0, input logic [ADDR_W-1:0] a0,
                      input logic r1, input logic w1, input logic [ADDR_W-1:0] a1);
    c0_rd = r0; c0_wr = w0; c0_addr = a0;
    c1_rd = r1; c1_wr = w1; c1_addr = a1;
    @(negedge clk);
    got0 = c0_rdata; got1 = c1_rdata;
    c0_rd = 1'b0; c0_wr = 1'b0; c1_rd = 1'b0; c1_wr = 1'b0;
  endtask

  task automatic idle();
    step(1'b0, 1'b0, '0, 1'b0, 1'b0, '0);
  endtask

  task automatic read_status(output logic [DATA_W-1:0] v);
    step(1'b1, 1'b0, STATUS_ADDR, 1'b0, 1'b0, '0);
    v = got0;
  endtask

  task automatic t_reset();
    logic [DATA_W-1:0] s;
    check("R1 c0_rdata after reset", c0_rdata, '0);
    check("R1 c1_rdata after reset", c1_rdata, '0);
    read_status(s);
    check("R1 all free", s, '0);
  endtask

  task automatic t_claim();
    logic [DATA_W-1:0] s;
    step(1'b1, 1'b0, la(5), 1'b0, 1'b0, '0);
    check("R2 claim lock 5", got0, 32'h1 << 5);
    step(1'b0, 1'b0, '0, 1'b1, 1'b0, la(0));
    check("R2 core1 claim lock 0", got1, 32'h1);
    step(1'b1, 1'b0, la(31), 1'b0, 1'b0, '0);
    check("R2 claim lock 31", got0, 32'h8000_0000);
    step(1'b0, 1'b0, '0, 1'b1, 1'b0, la(5));
    check("R3 core1 reads held lock 5", got1, '0);
    step(1'b1, 1'b0, la(5), 1'b0, 1'b0, '0);
    check("R3 core0 reads own held lock 5", got0, '0);
    read_status(s);
    check("R3 status after held reads", s, 32'h8000_0021);
  endtask

  task automatic t_release();
    logic [DATA_W-1:0] s;
    step(1'b0, 1'b0, '0, 1'b0, 1'b1, la(5));
    read_status(s);
    check("R4 core1 frees lock held by core0", s, 32'h8000_0001);
    step(1'b0, 1'b1, la(0), 1'b0, 1'b1, la(31));
    read_status(s);
    check("R4 both release", s, '0);
    step(1'b0, 1'b0, '0, 1'b1, 1'b0, la(5));
    check("R4 reclaim after release", got1, 32'h1 << 5);
    step(1'b1, 1'b1, la(5), 1'b0, 1'b0, '0);
    check("R6 own release+claim same cycle", got0, 32'h1 << 5);
    step(1'b0, 1'b1, la(5), 1'b0, 1'b0, '0);
  endtask

  task automatic t_same_lock();
    logic [DATA_W-1:0] s;
    step(1'b1, 1'b0, la(7), 1'b1, 1'b0, la(7));
    check("R5 core0 wins lock 7", got0, 32'h1 << 7);
    check("R5 core1 loses lock 7", got1, '0);
    read_status(s);
    check("R5 lock 7 taken once", s, 32'h1 << 7);
  endtask

  task automatic t_rel_vs_claim();
    logic [DATA_W-1:0] s;
    step(1'b0, 1'b1, la(7), 1'b1, 1'b0, la(7));
    check("R6 core1 claims as core0 frees", got1, 32'h1 << 7);
    step(1'b1, 1'b0, la(7), 1'b0, 1'b1, la(7));
    check("R6 core0 claims as core1 frees", got0, 32'h1 << 7);
    read_status(s);
    check("R6 lock 7 held after swap", s, 32'h1 << 7);
    step(1'b1, 1'b1, la(7), 1'b0, 1'b0, '0);
    step(1'b0, 1'b1, la(7), 1'b0, 1'b0, '0);
  endtask

  task automatic t_diff_locks();
    logic [DATA_W-1:0] s;
    step(1'b1, 1'b0, la(3), 1'b1, 1'b0, la(9));
    check("R7 core0 lock 3", got0, 32'h1 << 3);
    check("R7 core1 lock 9", got1, 32'h1 << 9);
    read_status(s);
    check("R7 both held", s, 32'h208);
  endtask

  task automatic t_status();
    logic [DATA_W-1:0] s1, s2;
    read_status(s1);
    read_status(s2);
    check("R8 status repeatable", s2, 32'h208);
    step(1'b0, 1'b1, STATUS_ADDR, 1'b0, 1'b1, STATUS_ADDR);
    step(1'b0, 1'b0, '0, 1'b1, 1'b0, STATUS_ADDR);
    check("R8 status write ignored", got1, s1);
    step(1'b1, 1'b0, la(11), 1'b1, 1'b0, STATUS_ADDR);
    check("R8 status shows start-of-cycle state", got1, 32'h208);
    check("R2 claim lock 11 during status read", got0, 32'h1 << 11);
    step(1'b0, 1'b1, la(11), 1'b0, 1'b0, '0);
  endtask

  task automatic t_unmapped();
    logic [DATA_W-1:0] s;
    step(1'b1, 1'b0, LOCK_BASE - 12'd8, 1'b1, 1'b0, LOCK_BASE + 12'h80);
    check("R9 read below window", got0, '0);
    check("R9 read above window", got1, '0);
    step(1'b0, 1'b1, LOCK_BASE - 12'd8, 1'b0, 1'b1, LOCK_BASE + 12'h80);
    read_status(s);
    check("R9 outside accesses change nothing", s, 32'h208);
  endtask

  task automatic t_idle();
    step(1'b1, 1'b0, la(20), 1'b1, 1'b0, la(21));
    check("R2 core0 lock 20", got0, 32'h1 << 20);
    idle();
    check("R10 c0 idle returns zero", got0, '0);
    check("R10 c1 idle returns zero", got1, '0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_claim();
    t_release();
    t_same_lock();
    t_rel_vs_claim();
    t_diff_locks();
    t_status();
    t_unmapped();
    t_idle();
    idle();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule